// File: doc/BRIEF.md
# GPIO Expander Port Register Bank

This block is the register core of an 8-pin general-purpose I/O expander. A host front end, which handles the serial bus and the address match, presents three single-cycle strobes to it: a command strobe that loads a register pointer, a write strobe that stores a byte at that pointer, and a read strobe that captures the byte at that pointer onto a read-data output. The pointer is kept after each access, so a host can issue one command byte and then read or write the same register many times.

Four registers sit behind the pointer. Register 0 holds the live pin levels. Register 1 holds the drive levels. Register 2 holds a per-bit inversion mask. Register 3 holds the per-bit direction. The block drives an output-enable and an output-data line for each external tri-state pad. It samples every pad level through a two-flop synchronizer, so the pad level is seen even on pins that the block itself drives.

Top module: `gpx_port_bank`

## Requirements
- R1: While `rst` is high on a clock edge, the drive register becomes 8'hFF, the inversion register 8'h00, the direction register 8'hFF, the pointer 0 and `rdata` 8'h00. After reset, `pad_oe` is all zero and `pad_out` is all ones.
- R2: A `cmd_we` pulse loads the pointer from `wdata[1:0]` and ignores `wdata[7:2]`. The pointer keeps its value until the next `cmd_we`. The codes are: 0 pin levels, 1 drive, 2 inversion, 3 direction.
- R3: A read at pointer 0 returns the synchronized pad levels XOR the inversion register, whatever each pin's direction. A change on `pad_in` can be read after two clock edges.
- R4: A write at pointer 0 changes no register. `pad_out`, `pad_oe` and later reads of registers 1 to 3 stay as they were.
- R5: A read at pointer 1 returns the stored drive byte, not the pad levels.
- R6: `pad_out[i]` equals drive bit i. `pad_oe[i]` is the inverse of direction bit i, where 1 means input with the driver off and 0 means driven output. Both follow a write one cycle later, and a drive bit has no effect on the pad while its pin is an input.
- R7: The inversion register can be written at pointer 2 and read back. It changes only the value returned at pointer 0.
- R8: The direction register can be written at pointer 3 and read back.
- R9: `rdata` is loaded only on the edge where `rd_en` is high. At all other times it holds its value.
- R10: When `cmd_we` and `wr_en` are high together, the write goes to the register selected by the old pointer, and the pointer takes the new value from the same `wdata` byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_we | input | 1 | Load the pointer from wdata[1:0] |
| wr_en | input | 1 | Write wdata into the register at the pointer |
| rd_en | input | 1 | Capture the register at the pointer into rdata |
| wdata | input | 8 | Command or data byte from the host front end |
| rdata | output | 8 | Registered read data |
| pad_in | input | 8 | Levels sampled from the pads |
| pad_out | output | 8 | Data toward the pad drivers |
| pad_oe | output | 8 | Per-pad driver enable, 1 drives |

## Verification
The assertions assume that `rst` is high on the first clock edge and that every strobe and data input carries a known value at each edge. The pad inputs may change at any time, since they pass through the synchronizer first. The bench changes all inputs at the falling edge and holds reset for several cycles from time zero, so every rising edge samples settled, defined values. Pad patterns are swept across all 256 values against several inversion masks and direction settings.

// File: rtl/gpx_pkg.sv
package gpx_pkg;
    localparam int unsigned BYTE_W = 8;
    localparam int unsigned SEL_W  = 2;

    typedef enum logic [SEL_W-1:0] {
        SEL_PINS   = 2'd0,
        SEL_DRIVE  = 2'd1,
        SEL_INVERT = 2'd2,
        SEL_DIR    = 2'd3
    } reg_sel_e;

    localparam logic [BYTE_W-1:0] DRIVE_RST  = 8'hFF;
    localparam logic [BYTE_W-1:0] INVERT_RST = 8'h00;
    localparam logic [BYTE_W-1:0] DIR_RST    = 8'hFF;
endpackage

// File: rtl/gpx_pad_sync.sv
module gpx_pad_sync #(
    parameter int unsigned WIDTH  = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] pad_async,
    output logic [WIDTH-1:0] pad_sync
);
    localparam int unsigned LAST = STAGES - 1;

    typedef struct packed {
        logic [STAGES-1:0][WIDTH-1:0] stage;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.stage[0] = pad_async;
        for (int s = 1; s < int'(STAGES); s++) begin
            st_d.stage[s] = st_q.stage[s-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign pad_sync = st_q.stage[LAST];

    initial begin
        stages_min_chk: assert (STAGES >= 2);
    end
endmodule

// File: rtl/gpx_host_decode.sv
module gpx_host_decode #(
    parameter int unsigned PTR_W = 2,
    localparam int unsigned NREG = 1 << PTR_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_we,
    input  logic             wr_en,
    input  logic [PTR_W-1:0] cmd_sel,
    output logic [PTR_W-1:0] ptr,
    output logic [NREG-1:0]  wr_sel
);
    typedef struct packed {
        logic [PTR_W-1:0] ptr;
    } dec_state_t;

    dec_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cmd_we) st_d.ptr = cmd_sel;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign ptr = st_q.ptr;

    // the write strobe follows the pointer held before this edge (R10)
    for (genvar i = 0; i < int'(NREG); i++) begin : g_wsel
        assign wr_sel[i] = wr_en && (st_q.ptr == PTR_W'(i));
    end

    // R2
    ptr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(st_q.ptr) |-> $past(cmd_we));

    // R2
    ptr_load_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_we |=> (st_q.ptr == $past(cmd_sel)));
endmodule

// File: rtl/gpx_port_regs.sv
module gpx_port_regs #(
    parameter int unsigned WIDTH = 8,
    parameter logic [WIDTH-1:0] DRIVE_INIT  = '1,
    parameter logic [WIDTH-1:0] INVERT_INIT = '0,
    parameter logic [WIDTH-1:0] DIR_INIT    = '1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_drive,
    input  logic             wr_invert,
    input  logic             wr_dir,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] drive,
    output logic [WIDTH-1:0] invert,
    output logic [WIDTH-1:0] dir
);
    typedef struct packed {
        logic [WIDTH-1:0] drive;
        logic [WIDTH-1:0] invert;
        logic [WIDTH-1:0] dir;
    } regs_state_t;

    localparam regs_state_t RST_VAL = '{drive: DRIVE_INIT, invert: INVERT_INIT, dir: DIR_INIT};

    regs_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_drive)  st_d.drive  = wdata;
        if (wr_invert) st_d.invert = wdata;
        if (wr_dir)    st_d.dir    = wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= RST_VAL;
        else     st_q <= st_d;
    end

    assign drive  = st_q.drive;
    assign invert = st_q.invert;
    assign dir    = st_q.dir;

    // R1
    reset_value_chk: assert property (@(posedge clk)
        rst |=> (drive == DRIVE_INIT && invert == INVERT_INIT && dir == DIR_INIT));

    // R7
    invert_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_invert |=> $stable(invert));

    // R8
    dir_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_dir |=> $stable(dir));
endmodule

// File: rtl/gpx_read_port.sv
module gpx_read_port #(
    parameter int unsigned WIDTH = 8,
    parameter int unsigned PTR_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rd_en,
    input  logic [PTR_W-1:0] ptr,
    input  logic [WIDTH-1:0] pins,
    input  logic [WIDTH-1:0] drive,
    input  logic [WIDTH-1:0] invert,
    input  logic [WIDTH-1:0] dir,
    output logic [WIDTH-1:0] rdata
);
    import gpx_pkg::*;

    typedef struct packed {
        logic [WIDTH-1:0] rdata;
    } rd_state_t;

    rd_state_t st_d, st_q;
    logic [WIDTH-1:0] sel_val;

    always_comb begin
        case (ptr)
            PTR_W'(SEL_PINS):   sel_val = pins ^ invert;
            PTR_W'(SEL_DRIVE):  sel_val = drive;
            PTR_W'(SEL_INVERT): sel_val = invert;
            PTR_W'(SEL_DIR):    sel_val = dir;
            default:            sel_val = '0;
        endcase
    end

    always_comb begin
        st_d = st_q;
        if (rd_en) st_d.rdata = sel_val;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign rdata = st_q.rdata;

    // R9
    rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(rdata) |-> $past(rd_en));

    // R5
    drive_read_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && ptr == PTR_W'(SEL_DRIVE)) |=> (rdata == $past(drive)));
endmodule

// File: rtl/gpx_port_bank.sv
module gpx_port_bank #(
    parameter int unsigned PORT_W      = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_we,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [PORT_W-1:0] wdata,
    output logic [PORT_W-1:0] rdata,
    input  logic [PORT_W-1:0] pad_in,
    output logic [PORT_W-1:0] pad_out,
    output logic [PORT_W-1:0] pad_oe
);
    import gpx_pkg::*;

    localparam int unsigned PTR_W = SEL_W;
    localparam int unsigned NREG  = 1 << PTR_W;

    logic [PTR_W-1:0]  ptr;
    logic [NREG-1:0]   wr_sel;
    logic [PORT_W-1:0] pins_sync;
    logic [PORT_W-1:0] drive, invert, dir;

    gpx_pad_sync #(.WIDTH(PORT_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst       (rst),
        .pad_async (pad_in),
        .pad_sync  (pins_sync)
    );

    gpx_host_decode #(.PTR_W(PTR_W)) u_dec (
        .clk     (clk),
        .rst     (rst),
        .cmd_we  (cmd_we),
        .wr_en   (wr_en),
        .cmd_sel (wdata[PTR_W-1:0]),
        .ptr     (ptr),
        .wr_sel  (wr_sel)
    );

    gpx_port_regs #(
        .WIDTH       (PORT_W),
        .DRIVE_INIT  (PORT_W'(DRIVE_RST)),
        .INVERT_INIT (PORT_W'(INVERT_RST)),
        .DIR_INIT    (PORT_W'(DIR_RST))
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_drive  (wr_sel[SEL_DRIVE]),
        .wr_invert (wr_sel[SEL_INVERT]),
        .wr_dir    (wr_sel[SEL_DIR]),
        .wdata     (wdata),
        .drive     (drive),
        .invert    (invert),
        .dir       (dir)
    );

    gpx_read_port #(.WIDTH(PORT_W), .PTR_W(PTR_W)) u_rd (
        .clk    (clk),
        .rst    (rst),
        .rd_en  (rd_en),
        .ptr    (ptr),
        .pins   (pins_sync),
        .drive  (drive),
        .invert (invert),
        .dir    (dir),
        .rdata  (rdata)
    );

    for (genvar p = 0; p < int'(PORT_W); p++) begin : g_pad
        assign pad_oe[p]  = ~dir[p];
        assign pad_out[p] = drive[p];
    end

    // R4
    pins_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        wr_sel[SEL_PINS] |=> ($stable(pad_out) && $stable(pad_oe)));

    // R6
    oe_change_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(pad_oe) |-> $past(wr_sel[SEL_DIR]));

    // R6
    out_change_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(pad_out) |-> $past(wr_sel[SEL_DRIVE]));

    // R3
    pin_read_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && ptr == PTR_W'(SEL_PINS)) |=> (rdata == $past(pins_sync ^ invert)));
endmodule

// File: tb/gpx_port_bank_bench.sv
`timescale 1ns/1ps
module gpx_port_bank_bench;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cmd_we = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] wdata = '0, pad_in = '0;
    logic [7:0] rdata, pad_out, pad_oe;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    gpx_port_bank u_gpx_port_bank (
        .clk(clk), .rst(rst), .cmd_we(cmd_we), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic sel(input logic [7:0] b);
        @(negedge clk); cmd_we = 1'b1; wdata = b;
        @(negedge clk); cmd_we = 1'b0;
    endtask

    task automatic wr(input logic [7:0] b);
        @(negedge clk); wr_en = 1'b1; wdata = b;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(output logic [7:0] b);
        @(negedge clk); rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0; b = rdata;
    endtask

    task automatic set_pads(input logic [7:0] v);
        @(negedge clk); pad_in = v;
        @(negedge clk); @(negedge clk);
    endtask

    initial begin
        logic [7:0] v;
        logic [7:0] inv_set [4] = '{8'h00, 8'hFF, 8'hA5, 8'h3C};
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset defaults
        chk("R1 pad_out", pad_out, 8'hFF);
        chk("R1 pad_oe", pad_oe, 8'h00);
        chk("R1 rdata", rdata, 8'h00);
        sel(8'h01); rd(v); chk("R1 drive", v, 8'hFF);
        sel(8'h02); rd(v); chk("R1 invert", v, 8'h00);
        sel(8'h03); rd(v); chk("R1 dir", v, 8'hFF);

        // R2 upper command bits ignored: 8'hFD selects 1
        sel(8'hFD); rd(v); chk("R2 ptr low bits", v, 8'hFF);
        // R2 pointer retained over repeated reads
        rd(v); chk("R2 ptr retained", v, 8'hFF);

        // R8 direction write and readback
        sel(8'h03); wr(8'h0F); rd(v); chk("R8 dir readback", v, 8'h0F);
        chk("R6 pad_oe", pad_oe, 8'hF0);
        // R5 and R6 drive register against pads
        sel(8'h01); wr(8'h5A);
        chk("R6 pad_out", pad_out, 8'h5A);
        set_pads(8'hC3);
        rd(v); chk("R5 drive read not pins", v, 8'h5A);

        // R3 sweep every pad value against several masks and directions
        for (int m = 0; m < 4; m++) begin
            sel(8'h02); wr(inv_set[m]);
            rd(v); chk("R7 invert readback", v, inv_set[m]);
            sel(8'h03); wr(8'(m * 8'h55));
            sel(8'h00);
            for (int p = 0; p < 256; p++) begin
                set_pads(8'(p));
                rd(v); chk("R3 pin read", v, 8'(p) ^ inv_set[m]);
            end
        end

        // R7 inversion leaves other registers and pads untouched
        sel(8'h02); wr(8'hFF);
        sel(8'h01); rd(v); chk("R7 drive unaffected", v, 8'h5A);
        chk("R7 pad_out unaffected", pad_out, 8'h5A);
        sel(8'h02); wr(8'h00);

        // R4 writes to register 0 ignored
        sel(8'h03); wr(8'h00);
        sel(8'h00); wr(8'h81);
        chk("R4 pad_out", pad_out, 8'h5A);
        chk("R4 pad_oe", pad_oe, 8'hFF);
        sel(8'h01); rd(v); chk("R4 drive", v, 8'h5A);
        sel(8'h02); rd(v); chk("R4 invert", v, 8'h00);
        sel(8'h03); rd(v); chk("R4 dir", v, 8'h00);

        // R6 drive bits have no pad effect on input pins
        wr(8'hFF);
        chk("R6 oe off for inputs", pad_oe, 8'h00);
        sel(8'h01); rd(v); chk("R6 drive kept", v, 8'h5A);

        // R9 rdata held without rd_en
        sel(8'h02); wr(8'h77);
        sel(8'h03);
        @(negedge clk); chk("R9 rdata held", rdata, 8'h5A);

        // R10 command and write together: write uses old pointer 3
        @(negedge clk); cmd_we = 1'b1; wr_en = 1'b1; wdata = 8'hA6;
        @(negedge clk); cmd_we = 1'b0; wr_en = 1'b0;
        chk("R10 old ptr written", pad_oe, 8'h59);
        rd(v); chk("R10 new ptr", v, 8'h77);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule